// File: doc/BRIEF.md
# Byte-Handshake I2C Master

This block is a register-programmed I2C master that moves exactly one byte per software handshake. Software loads a target address and a direction bit into the transfer register; the controller then issues a START and the address byte, raises an interrupt and parks the bus with SCL held low. Each further byte is released only when software sets a ready bit in the control register. The interrupt is raised again after every byte, and SCL stays low until software answers.

Two end-of-transfer bits are set ahead of time and shape how a transfer ends. With the receive-end bit set, the next received byte is answered with NACK and a STOP follows without further software action. The transmit-end bit, written together with ready, turns the next handshake into a STOP. This also closes an address-only write. A write that leaves both bits clear keeps the bus after its last byte, so that a new transfer-register write produces a repeated START. The SCL timing comes from a divider register: each quarter of an SCL period lasts that many clock cycles.

Register map (word address on `bus_addr`): 0 control {txe[3], rxe[2], rdy[1], en[0]}; 1 transfer {read[8], target[6:0]}; 2 data {rx byte[15:8], tx byte[7:0]}; 3 status {irq[2], nack[1], idle[0]}; 4 divider [15:0].

Top module: `i2c_hs_master`

## Requirements
- R1: After reset, status reads 16'h0001 (idle=1, nack=0, irq=0), `irq` is low, `scl_oe` and `sda_oe` are low, and the divider at address 4 reads CLK_HZ/(4*SCL_HZ), which is 500 by default.
- R2: A write to address 1 while idle with en=1 issues START and then the byte {target[6:0], read}, MSB first. After the acknowledge bit, status bit 1 (nack) holds the sampled acknowledge: 1 means no target answered.
- R3: After every byte, `irq` rises and SCL is held low indefinitely until control bit 1 (rdy) is set. The controller clears rdy itself when it consumes it.
- R4: In a write transfer, each consumed rdy sends data[7:0] and updates nack from the target's acknowledge.
- R5: In a read transfer, each consumed rdy receives one byte, which is returned in data[15:8]. The byte is acknowledged when control bit 2 (rxe) is 0. When rxe is 1 it is answered with NACK and a STOP follows, after which status idle reads 1.
- R6: Consuming rdy while control bit 3 (txe) is 1 produces a STOP instead of a byte, and the block returns to idle. This applies equally after only the address byte.
- R7: A write to address 1 while the bus is parked after a byte issues a repeated START with no STOP in between.
- R8: A write to address 1 is ignored while a byte or bus condition is in progress, or while en=0. The latched target and direction do not change.
- R9: Writing 1 to status bit 2 clears irq, and writing 1 to status bit 1 clears nack. Writing 0 leaves them unchanged.
- R10: SCL high time is 2*DIV clock cycles, where DIV is the value in the divider register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_we | input | 1 | register write strobe |
| bus_addr | input | 3 | register word address |
| bus_wdata | input | 16 | register write data |
| bus_rdata | output | 16 | register read data, combinational from bus_addr |
| irq | output | 1 | per-byte interrupt, level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | sensed SDA line level |

## Verification
The bench drives a behavioural target on a wired-AND bus. It aims at the points where a handshake design tends to slip. If the controller ran on without waiting for rdy, SCL would be seen released during a long pause. If rxe were applied one byte late, the target would record an ACK on the final byte and keep driving data. If a transfer-register write were accepted while a byte was in progress, the target would see an extra START or a changed direction. If a repeated START emitted a STOP first, the target's STOP count would rise. The address-only write, the NACK to an absent address and the one-byte read with rxe set before the start are run as directed cases. Random write and read lengths are checked against a byte log and a known target memory.

// File: rtl/i2c_hs_master.sv
module i2c_hs_master #(
  parameter int CLK_HZ = 200_000_000,
  parameter int SCL_HZ = 100_000,
  parameter int DIV_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_i
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(CLK_HZ / (4 * SCL_HZ));

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_WAIT, S_RSTART, S_STOP} st_t;

  st_t st;
  logic en, rdy, rx_end, tx_end;
  logic [6:0] tgt;
  logic rw, is_addr, ack_s, nack, irq_r;
  logic [7:0] txd, rxd, sh;
  logic [DIV_W-1:0] div, cnt;
  logic [1:0] q;
  logic [3:0] bn;
  logic scl_l, sda_l, sda_d;

  wire wr_ctrl = bus_we && bus_addr == 3'd0;
  wire wr_xfer = bus_we && bus_addr == 3'd1;
  wire wr_data = bus_we && bus_addr == 3'd2;
  wire wr_stat = bus_we && bus_addr == 3'd3;
  wire wr_div  = bus_we && bus_addr == 3'd4;

  wire idle   = st == S_IDLE;
  wire active = st == S_START || st == S_BIT || st == S_RSTART || st == S_STOP;
  wire [DIV_W-1:0] lim = (div == '0) ? DIV_W'(1) : div;
  wire tick   = active && cnt >= lim - DIV_W'(1);
  wire last_q = tick && q == 2'd3;
  wire xmit   = is_addr || !rw;
  wire byte_done = st == S_BIT && last_q && bn == 4'd8;
  wire go = wr_xfer && en && (st == S_IDLE || st == S_WAIT);

  assign irq = irq_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (!active || tick) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= 2'd0;
    else if (!active) q <= 2'd0;
    else if (tick) q <= q + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tgt <= '0;
      rw <= 1'b0;
      sh <= '0;
      bn <= '0;
      is_addr <= 1'b0;
      ack_s <= 1'b0;
      rxd <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (go) begin
            st <= S_START;
            tgt <= bus_wdata[6:0];
            rw <= bus_wdata[8];
            sh <= {bus_wdata[6:0], bus_wdata[8]};
            is_addr <= 1'b1;
          end
        S_START, S_RSTART:
          if (last_q) begin
            st <= S_BIT;
            bn <= '0;
          end
        S_BIT:
          if (tick) begin
            if (q == 2'd2) begin
              if (bn == 4'd8) ack_s <= sda_i;
              else if (!xmit) sh <= {sh[6:0], sda_i};
            end
            if (q == 2'd3) begin
              if (bn == 4'd8) begin
                if (!xmit) rxd <= sh;
                is_addr <= 1'b0;
                st <= (!xmit && rx_end) ? S_STOP : S_WAIT;
              end else begin
                bn <= bn + 4'd1;
                if (xmit) sh <= {sh[6:0], 1'b0};
              end
            end
          end
        S_WAIT:
          if (go) begin
            st <= S_RSTART;
            tgt <= bus_wdata[6:0];
            rw <= bus_wdata[8];
            sh <= {bus_wdata[6:0], bus_wdata[8]};
            is_addr <= 1'b1;
          end else if (rdy) begin
            if (tx_end) st <= S_STOP;
            else begin
              st <= S_BIT;
              bn <= '0;
              sh <= rw ? 8'h00 : txd;
            end
          end
        S_STOP:
          if (last_q) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {tx_end, rx_end, rdy, en} <= 4'b0;
    else if (wr_ctrl) {tx_end, rx_end, rdy, en} <= bus_wdata[3:0];
    else if (go || (st == S_WAIT && rdy)) rdy <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) nack <= 1'b0;
    else if (byte_done && xmit) nack <= ack_s;
    else if (go || (wr_stat && bus_wdata[1])) nack <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_r <= 1'b0;
    else if (byte_done) irq_r <= 1'b1;
    else if (wr_stat && bus_wdata[2]) irq_r <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) txd <= '0;
    else if (wr_data) txd <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= DIV_RST;
    else if (wr_div) div <= bus_wdata[DIV_W-1:0];

  always_comb begin
    scl_l = 1'b0;
    sda_l = 1'b0;
    case (st)
      S_START:  begin scl_l = q == 2'd3; sda_l = q != 2'd0; end
      S_RSTART: begin scl_l = q == 2'd0 || q == 2'd3; sda_l = q[1]; end
      S_BIT: begin
        scl_l = !q[1];
        sda_l = (bn == 4'd8) ? (!xmit && !rx_end) : (xmit && !sh[7]);
      end
      S_WAIT:   scl_l = 1'b1;
      S_STOP:   begin scl_l = !q[1]; sda_l = q == 2'd1 || q == 2'd2; end
      default:  ;
    endcase
  end

  // SDA trails SCL by one clock so data never moves on an SCL edge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_oe, sda_d, sda_oe} <= 3'b0;
    else begin
      scl_oe <= scl_l;
      sda_d <= sda_l;
      sda_oe <= sda_d;
    end

  always_comb
    case (bus_addr)
      3'd0: bus_rdata = {12'b0, tx_end, rx_end, rdy, en};
      3'd1: bus_rdata = {7'b0, rw, 1'b0, tgt};
      3'd2: bus_rdata = {rxd, txd};
      3'd3: bus_rdata = {13'b0, irq_r, nack, idle};
      3'd4: bus_rdata = 16'(div);
      default: bus_rdata = '0;
    endcase
endmodule

module i2c_hs_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  st,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        irq,
  input logic        rdy,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [15:0] bus_wdata,
  input logic [6:0]  tgt,
  input logic        byte_done
);
  localparam logic [2:0] C_IDLE = 3'd0, C_BIT = 3'd2, C_WAIT = 3'd3;

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_IDLE |-> !scl_oe && !sda_oe);

  p_data_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_BIT && $past(st) == C_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  p_hold_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |=> scl_oe);

  p_rdy_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WAIT && rdy && !(bus_we && bus_addr == 3'd0)) |=> !rdy);

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_BIT && bus_we && bus_addr == 3'd1) |=> $stable(tgt));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd3 && bus_wdata[2] && !byte_done) |=> !irq);
endmodule

bind i2c_hs_master i2c_hs_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .rdy(rdy), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tgt(tgt), .byte_done(byte_done)
);

// File: tb/i2c_hs_master_tb.sv
module i2c_hs_master_tb;
  localparam logic [6:0] SADDR = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0, bus_rdata;
  logic irq, scl_oe, sda_oe;
  logic sdrv = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || sdrv);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_hs_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  // behavioural target: 0 idle, 1 address, 2 receive, 3 send
  int s_state = 0, bitcnt = 0, ptr = 0, wcnt = 0, starts = 0, stops = 0;
  bit ackph = 1'b0, srw = 1'b0, mack = 1'b0, last_mack = 1'b0;
  logic [7:0] shreg = 8'd0;
  logic [6:0] s_addr = 7'd0;
  logic [7:0] rmem [0:7];
  logic [7:0] wlog [0:255];

  always @(negedge sda_line) if (scl_line) begin
    starts++; s_state = 1; bitcnt = 0; ackph = 0; ptr = 0; sdrv = 0;
  end
  always @(posedge sda_line) if (scl_line) begin
    stops++; s_state = 0; sdrv = 0;
  end
  always @(posedge scl_line) begin
    if ((s_state == 1 || s_state == 2) && bitcnt < 8) begin
      shreg = {shreg[6:0], sda_line}; bitcnt++;
    end else if (s_state == 3) begin
      if (bitcnt < 8) bitcnt++;
      else if (bitcnt == 8) begin mack = sda_line; last_mack = mack; bitcnt = 9; end
    end
  end
  always @(negedge scl_line) begin
    if (s_state == 1 || s_state == 2) begin
      if (bitcnt == 8 && !ackph) begin
        if (s_state == 1) begin
          s_addr = shreg[7:1];
          if (shreg[7:1] == SADDR) begin sdrv = 1; srw = shreg[0]; ackph = 1; end
          else s_state = 0;
        end else begin
          wlog[wcnt[7:0]] = shreg; wcnt++; sdrv = 1; ackph = 1;
        end
      end else if (ackph) begin
        sdrv = 0; ackph = 0; bitcnt = 0;
        if (s_state == 1 && srw) begin s_state = 3; sdrv = !rmem[ptr[2:0]][7]; end
        else if (s_state == 1) s_state = 2;
      end
    end else if (s_state == 3) begin
      if (bitcnt > 0 && bitcnt < 8) sdrv = !rmem[ptr[2:0]][7 - bitcnt];
      else if (bitcnt == 8) sdrv = 0;
      else if (bitcnt == 9) begin
        if (!mack) begin ptr++; bitcnt = 0; sdrv = !rmem[ptr[2:0]][7]; end
        else begin s_state = 0; sdrv = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_irq(input string tag, input bit clr);
    int n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq, tag, 0, 1);
    if (clr) reg_wr(3'd3, 16'h0004);
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] d;
    int n = 0;
    reg_rd(3'd3, d);
    while (!d[0] && n < 20000) begin reg_rd(3'd3, d); n++; end
    chk(d[0], tag, 0, 1);
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    return rmem[i % 8];
  endfunction

  task automatic do_write(input int n, input bit stop);
    logic [15:0] d;
    logic [7:0] b [0:7];
    int base = wcnt;
    reg_wr(3'd0, 16'h0001);
    reg_wr(3'd1, {9'd0, SADDR});
    wait_irq("R2 addr irq", 1);
    reg_rd(3'd3, d); chk(!d[1], "R2 addr ack", d[1], 0);
    chk(s_addr == SADDR, "R2 address seen", s_addr, SADDR);
    for (int i = 0; i < n; i++) begin
      b[i] = 8'($urandom);
      reg_wr(3'd2, {8'd0, b[i]});
      reg_wr(3'd0, 16'h0003);
      wait_irq("R4 byte irq", 1);
      reg_rd(3'd3, d); chk(!d[1], "R4 data ack", d[1], 0);
    end
    for (int i = 0; i < n; i++)
      chk(wlog[8'(base + i)] == b[i], "R4 written byte", wlog[8'(base + i)], b[i]);
    if (stop) begin
      reg_wr(3'd0, 16'h000B);
      wait_idle("R6 stop after write");
    end
  endtask

  task automatic do_read(input int n, input bit start_new);
    logic [15:0] d;
    int st0 = stops;
    reg_wr(3'd0, (n == 1) ? 16'h0005 : 16'h0001);
    reg_wr(3'd1, {7'd0, 1'b1, 1'b0, SADDR});
    wait_irq("R2 read addr irq", 1);
    for (int i = 0; i < n; i++) begin
      reg_wr(3'd0, (i == n - 1) ? 16'h0007 : 16'h0003);
      wait_irq("R5 read irq", 1);
      reg_rd(3'd2, d);
      chk(d[15:8] == exp_rd(i), "R5 read byte", d[15:8], exp_rd(i));
    end
    wait_idle("R5 auto stop");
    chk(last_mack == 1'b1, "R5 final NACK", last_mack, 1);
    chk(stops == st0 + 1, "R5 one stop", stops, st0 + 1);
    if (start_new) ;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      report;
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int cnt, st0, sp0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) rmem[i] = 8'($urandom);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1
    reg_rd(3'd3, d); chk(d == 16'h0001, "R1 status", d, 1);
    chk(!irq && !scl_oe && !sda_oe, "R1 outputs", {irq, scl_oe, sda_oe}, 0);
    reg_rd(3'd4, d); chk(d == 16'd500, "R1 divider", d, 500);

    // R8 disabled start ignored
    reg_wr(3'd1, {9'd0, SADDR});
    repeat (100) @(negedge clk);
    reg_rd(3'd3, d); chk(d[0] && starts == 0, "R8 disabled ignore", starts, 0);

    // R10 SCL high time, then R3, R9, R6 on an address-only write
    reg_wr(3'd4, 16'd6);
    reg_wr(3'd0, 16'h0001);
    reg_wr(3'd1, {9'd0, SADDR});
    @(negedge scl_line); @(posedge scl_line);
    cnt = 0;
    while (scl_line) begin @(negedge clk); if (scl_line) cnt++; end
    chk(cnt == 12, "R10 scl high", cnt, 12);
    wait_irq("R2 irq", 0);
    reg_rd(3'd3, d); chk(d[1] == 1'b0, "R2 nack clear", d[1], 0);
    repeat (300) @(negedge clk);
    chk(scl_oe == 1'b1, "R3 scl held", scl_oe, 1);
    reg_rd(3'd3, d); chk(d[2:0] == 3'b100, "R3 parked status", d[2:0], 4);
    reg_wr(3'd3, 16'h0000); chk(irq == 1'b1, "R9 write zero keeps irq", irq, 1);
    reg_wr(3'd3, 16'h0004); chk(irq == 1'b0, "R9 w1c irq", irq, 0);
    sp0 = stops;
    reg_wr(3'd0, 16'h000B);
    wait_idle("R6 address-only stop");
    chk(stops == sp0 + 1 && wcnt == 0, "R6 stop no data", stops, sp0 + 1);
    reg_rd(3'd0, d); chk(d[1] == 1'b0, "R3 rdy self clear", d[1], 0);
    reg_wr(3'd4, 16'd4);

    // directed write and reads
    do_write(3, 1);
    do_read(1, 0);
    do_read(3, 0);

    // R7 repeated start
    st0 = starts; sp0 = stops;
    do_write(1, 0);
    reg_wr(3'd0, 16'h0001);
    reg_wr(3'd1, {7'd0, 1'b1, 1'b0, SADDR});
    wait_irq("R7 rstart addr", 1);
    chk(stops == sp0, "R7 no stop before rstart", stops, sp0);
    chk(starts == st0 + 2, "R7 two starts", starts, st0 + 2);
    for (int i = 0; i < 2; i++) begin
      reg_wr(3'd0, (i == 1) ? 16'h0007 : 16'h0003);
      wait_irq("R7 read irq", 1);
      reg_rd(3'd2, d); chk(d[15:8] == exp_rd(i), "R7 read byte", d[15:8], exp_rd(i));
    end
    wait_idle("R7 end");

    // R2/R9 address NACK
    reg_wr(3'd0, 16'h0001);
    reg_wr(3'd1, 16'h003C);
    wait_irq("R2 nack irq", 1);
    reg_rd(3'd3, d); chk(d[1] == 1'b1, "R2 address nack", d[1], 1);
    reg_wr(3'd3, 16'h0002);
    reg_rd(3'd3, d); chk(d[1] == 1'b0, "R9 w1c nack", d[1], 0);
    reg_wr(3'd0, 16'h000B);
    wait_idle("R6 stop after nack");

    // R8 busy ignore
    st0 = starts;
    reg_wr(3'd0, 16'h0001);
    reg_wr(3'd1, {9'd0, SADDR});
    wait_irq("R8 addr", 1);
    reg_wr(3'd2, 16'h005A);
    reg_wr(3'd0, 16'h0003);
    repeat (40) @(negedge clk);
    reg_wr(3'd1, 16'h013C);
    wait_irq("R8 byte", 1);
    reg_rd(3'd1, d); chk(d == {9'd0, SADDR}, "R8 target kept", d, {9'd0, SADDR});
    reg_rd(3'd3, d); chk(d[1] == 1'b0, "R8 ack kept", d[1], 0);
    chk(wlog[8'(wcnt - 1)] == 8'h5A, "R8 byte sent", wlog[8'(wcnt - 1)], 8'h5A);
    reg_wr(3'd0, 16'h000B);
    wait_idle("R8 end");
    chk(starts == st0 + 1, "R8 single start", starts, st0 + 1);

    // random mix
    for (int t = 0; t < 8; t++) begin
      if ($urandom_range(0, 1) == 0) do_write($urandom_range(1, 4), 1);
      else do_read($urandom_range(1, 4), 0);
    end

    done = 1'b1;
    report;
    $finish;
  end
endmodule